// File: doc/BRIEF.md
# Dithered Sample-to-DAC Level Driver

This block takes a 16-bit unsigned sample from a host and turns it into an 8-bit level for a DAC, refreshed on every system clock. An 8-bit DAC alone would lose the sample's lower byte. Here the upper byte is the base level, and the lower byte sets how often the level is raised by one step. Averaged over time, the output therefore carries the full 16-bit value. The raise can be driven by a pseudo-random threshold or by a ramp that repeats every 256 clocks. A separate mode sends the raw pseudo-random byte straight to the output, which gives a noise source.

A 5-bit mode code selects the behaviour. A small load controller tracks whether a sample has ever been written. It has two states. `ST_EMPTY` is entered on reset and holds until the first write. The transition `EMPTY_TO_LOADED` fires on the first clock edge that sees the write strobe high. `ST_LOADED` then holds until the next reset. While the controller is in `ST_EMPTY`, both dither modes output zero instead of a meaningless level.

The sample register, the LFSR, the ramp counter and the load state are all registers. The output level is combinational logic over those registers.

Top module: `dac_dither_top`

## Requirements
- R1: While reset is high, the LFSR holds 16'hACE1, the ramp counter holds 0, the stored sample is 0 and the load state is `ST_EMPTY`. With mode 0 the level is 0, and with mode 1 the level is 8'hE1.
- R2: The mode code is 5 bits wide. Code 1 selects pseudo-random output, code 2 selects random dither and code 3 selects ramp (PWM) dither. Every other code drives a level of 0.
- R3: In mode 1 the level equals bits [7:0] of a 16-bit right-shifting Galois LFSR. On each clock out of reset, the LFSR shifts right by one, and when the bit shifted out is 1 it is XORed with 16'hB400.
- R4: In mode 2 with a sample loaded, let H be bits [15:8] and L be bits [7:0] of the stored sample. The level is H+1 when LFSR bits [7:0] are less than L, and H otherwise. Over one full LFSR period of 65535 clocks, the raised level appears exactly 256*L-1 times when L>0.
- R5: In mode 3 with a sample loaded, an 8-bit ramp counter starts at 0 after reset, increments on every clock and wraps from 255 to 0. The level is H+1 when the counter is less than L, and H otherwise.
- R6: The raise saturates: when H is 255, the level stays 255 whatever the value of L.
- R7: Before the first write after reset, modes 2 and 3 give a level of 0. Mode 1 is not affected by the load state.
- R8: A clock edge with the write strobe high stores the sample data, and the new value governs the level straight after that edge. Sample data presented while the strobe is low is ignored.
- R9: The LFSR state is never zero.
- R10: In mode 3, over any 256 consecutive clocks the raised level appears exactly L times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 5 | Mode code (0 off, 1 noise, 2 random dither, 3 ramp dither) |
| wr_stb | input | 1 | Sample write strobe |
| wr_data | input | 16 | Sample to store |
| dac_level | output | 8 | DAC level |

## Verification
Every result is due within the same cycle as the edge that causes it. A write, an LFSR step or a counter step takes effect at one rising edge, and the level then settles through combinational logic only, so it is valid before the next falling edge. The bench keeps its own model of the LFSR, the ramp, the stored sample and the load state, updated at each rising edge from the stimulus. It drives and compares only at falling edges, so each check sees the level exactly one register stage after the stimulus. The averaging checks count raised levels across full periods: 256 clocks for the ramp and 65535 clocks for the LFSR.

// File: rtl/dac_dither_pkg.sv
package dac_dither_pkg;

    localparam int MODE_W = 5;

    localparam logic [MODE_W-1:0] MD_NOISE = 5'd1;
    localparam logic [MODE_W-1:0] MD_RDITH = 5'd2;
    localparam logic [MODE_W-1:0] MD_PDITH = 5'd3;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } load_st_e;

endpackage

// File: rtl/dd_lfsr.sv
module dd_lfsr #(
    parameter int         W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] state
);

    logic [W-1:0] nxt;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (i == W - 1) begin : g_top
                assign nxt[i] = state[0] & TAPS[i];
            end else begin : g_mid
                assign nxt[i] = state[i+1] ^ (state[0] & TAPS[i]);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) state <= SEED;
        else     state <= nxt;
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state != '0);  // R9

endmodule

// File: rtl/dd_ramp.sv
module dd_ramp #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count == $past(count) + 1'b1);  // R5

endmodule

// File: rtl/dd_raise.sv
module dd_raise #(
    parameter int W = 8
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] frac,
    input  logic [W-1:0] thresh,
    output logic [W-1:0] level
);

    localparam logic [W-1:0] TOP = '1;

    logic bump;

    always_comb begin
        bump  = (thresh < frac) && (base != TOP);
        level = bump ? base + 1'b1 : base;
    end

    always_comb begin
        AST_RAISE_BOUND: assert (level >= base && (level - base) <= 1);  // R6
    end

endmodule

// File: rtl/dac_dither_top.sv
module dac_dither_top
    import dac_dither_pkg::*;
#(
    parameter int               SAMPLE_W = 16,
    parameter int               LFSR_W   = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [MODE_W-1:0]   mode,
    input  logic                wr_stb,
    input  logic [SAMPLE_W-1:0] wr_data,
    output logic [SAMPLE_W/2-1:0] dac_level
);

    localparam int LVL_W = SAMPLE_W / 2;

    load_st_e             st_q, st_d;
    logic [SAMPLE_W-1:0]  sample_q;
    logic [LFSR_W-1:0]    lfsr_q;
    logic [LVL_W-1:0]     ramp_q;
    logic [LVL_W-1:0]     rnd_byte;
    logic [LVL_W-1:0]     lvl_rand, lvl_pwm;

    assign rnd_byte = lfsr_q[LVL_W-1:0];

    dd_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk(clk), .rst(rst), .state(lfsr_q)
    );

    dd_ramp #(.W(LVL_W)) u_ramp (
        .clk(clk), .rst(rst), .count(ramp_q)
    );

    dd_raise #(.W(LVL_W)) u_raise_rand (
        .base(sample_q[SAMPLE_W-1:LVL_W]), .frac(sample_q[LVL_W-1:0]),
        .thresh(rnd_byte), .level(lvl_rand)
    );

    dd_raise #(.W(LVL_W)) u_raise_pwm (
        .base(sample_q[SAMPLE_W-1:LVL_W]), .frac(sample_q[LVL_W-1:0]),
        .thresh(ramp_q), .level(lvl_pwm)
    );

    // next-state logic: EMPTY_TO_LOADED on the first write
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY:  if (wr_stb) st_d = ST_LOADED;
            ST_LOADED: st_d = ST_LOADED;
            default:   st_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_EMPTY;
            sample_q <= '0;
        end else begin
            st_q <= st_d;
            if (wr_stb) sample_q <= wr_data;
        end
    end

    // output logic
    always_comb begin
        dac_level = '0;
        unique case (mode)
            MD_NOISE: dac_level = rnd_byte;
            MD_RDITH: if (st_q == ST_LOADED) dac_level = lvl_rand;
            MD_PDITH: if (st_q == ST_LOADED) dac_level = lvl_pwm;
            default:  dac_level = '0;
        endcase
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (st_q == ST_LOADED) && (sample_q == $past(wr_data)));  // R8

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(sample_q));  // R8

    AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_EMPTY && (mode == MD_RDITH || mode == MD_PDITH)) |-> dac_level == '0);  // R7

endmodule

// File: tb/tb_dac_dither_top.sv
module tb_dac_dither_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mode = 5'd0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [7:0]  dac_level;

    int checks = 0;
    int fails  = 0;

    // independent reference state
    logic [15:0] m_lfsr;
    logic [7:0]  m_cnt;
    logic [15:0] m_samp;
    logic        m_loaded;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_dither_top dut (
        .clk(clk), .rst(rst), .mode(mode), .wr_stb(wr_stb),
        .wr_data(wr_data), .dac_level(dac_level)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_lfsr <= 16'hACE1; m_cnt <= 8'd0; m_samp <= 16'h0; m_loaded <= 1'b0;
        end else begin
            m_lfsr <= {1'b0, m_lfsr[15:1]} ^ (m_lfsr[0] ? 16'hB400 : 16'h0);
            m_cnt  <= m_cnt + 8'd1;
            if (wr_stb) begin m_samp <= wr_data; m_loaded <= 1'b1; end
        end
    end

    function automatic logic [7:0] raise(input logic [7:0] h, input logic [7:0] l,
                                         input logic [7:0] t);
        if (t < l && h != 8'hFF) return h + 8'd1;
        return h;
    endfunction

    function automatic logic [7:0] expected();
        case (mode)
            5'd1: return m_lfsr[7:0];
            5'd2: return m_loaded ? raise(m_samp[15:8], m_samp[7:0], m_lfsr[7:0]) : 8'h0;
            5'd3: return m_loaded ? raise(m_samp[15:8], m_samp[7:0], m_cnt) : 8'h0;
            default: return 8'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] exp);
        checks++;
        if (dac_level !== exp) begin
            fails++;
            $display("FAIL %s: level=%h expected=%h", tag, dac_level, exp);
        end
    endtask

    task automatic run_cmp(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tag, expected());
        end
    endtask

    task automatic write(input logic [15:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0; wr_data = ~d;
    endtask

    task automatic t_reset();
        rst = 1'b1; mode = 5'd0;
        repeat (2) @(negedge clk);
        check("R1 off level in reset", 8'h00);
        mode = 5'd1; #1;
        check("R1 seed low byte", 8'hE1);
        mode = 5'd0;
        rst = 1'b0;
    endtask

    task automatic t_empty();
        mode = 5'd2; run_cmp("R7 random dither before write", 20);
        mode = 5'd3; run_cmp("R7 ramp dither before write", 20);
        mode = 5'd1; run_cmp("R7 noise before write", 5);
    endtask

    task automatic t_noise();
        mode = 5'd1; run_cmp("R3 noise sequence", 300);
    endtask

    task automatic t_other_codes();
        for (int c = 4; c < 32; c += 9) begin
            mode = 5'(c); run_cmp("R2 unused code gives zero", 3);
        end
        mode = 5'd0; run_cmp("R2 code zero gives zero", 3);
    endtask

    task automatic t_rand_dither();
        mode = 5'd2;
        write(16'h3480); run_cmp("R4 random dither 3480", 200);
        write(16'h7701); run_cmp("R4 random dither 7701", 100);
        write(16'h1200); run_cmp("R4 random dither zero fraction", 50);
    endtask

    task automatic t_pwm_dither();
        mode = 5'd3;
        write(16'h40C3); run_cmp("R5 ramp dither 40C3", 300);
        write(16'hA010); run_cmp("R5 ramp dither A010", 100);
    endtask

    task automatic t_saturate();
        mode = 5'd3; write(16'hFFFF); run_cmp("R6 saturate ramp", 260);
        mode = 5'd2; run_cmp("R6 saturate random", 100);
    endtask

    task automatic t_write_timing();
        mode = 5'd3;
        write(16'h1000);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = 16'h55FF;
        @(negedge clk);
        wr_stb = 1'b0;
        check("R8 new sample right after edge", (m_cnt < 8'hFF) ? 8'h56 : 8'h55);
        wr_data = 16'h0000;
        run_cmp("R8 data ignored without strobe", 20);
        checks++;
        if (m_samp !== 16'h55FF || (dac_level != 8'h55 && dac_level != 8'h56)) begin
            fails++;
            $display("FAIL R8 held sample: level=%h expected=55 or 56", dac_level);
        end
    endtask

    task automatic t_pwm_average();
        int hits = 0;
        mode = 5'd3; write(16'h2050);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (dac_level == 8'h21) hits++;
        end
        checks++;
        if (hits != 8'h50) begin
            fails++;
            $display("FAIL R10 ramp average: raised=%0d expected=%0d", hits, 8'h50);
        end
    endtask

    task automatic t_rand_average();
        int hits = 0;
        mode = 5'd2; write(16'h4020);
        for (int i = 0; i < 65535; i++) begin
            @(negedge clk);
            if (dac_level == 8'h41) hits++;
        end
        checks++;
        if (hits != 8191) begin
            fails++;
            $display("FAIL R4 random average: raised=%0d expected=%0d", hits, 8191);
        end
    endtask

    task automatic t_lfsr_nonzero();
        mode = 5'd1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            checks++;
            if (m_lfsr == 16'h0 || dac_level !== m_lfsr[7:0]) begin
                fails++;
                $display("FAIL R9 lfsr: level=%h expected=%h", dac_level, m_lfsr[7:0]);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_empty();
        t_noise();
        t_other_codes();
        t_rand_dither();
        t_pwm_dither();
        t_saturate();
        t_write_timing();
        t_pwm_average();
        t_rand_average();
        t_lfsr_nonzero();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule